// File: doc/BRIEF.md
# Physical Register Reference Counter

This block keeps a use count for every physical register so that a register move can be removed at rename by letting two architectural names share one physical register. Every cycle, a set of allocate ports raise the count of the register they name and a matching set of deallocate ports lower it. All ports that name the same register in one cycle are added together, and the net change is applied in a single update.

When a deallocation takes a register's count from a nonzero value to zero, the register is handed back for reuse. It appears on the release port of the same number as the deallocate port that caused it. The release is registered once more after the counter update, so the counter path stays off the free list's timing path. Physical register 0 is pinned: it is never counted and never handed back.

Top module: `preg_refcount`

## Requirements
- R1: While reset is asserted and on the first two clock edges after it, every releaseValid bit is 0.
- R2: After reset, physical registers 1 to NUM_ARCH-1 hold a count of one and all registers from NUM_ARCH upward hold zero, so a single deallocation of register 5 releases it.
- R3: An allocate port with valid set adds one to the count of the register it names, and a deallocate port with valid set subtracts one.
- R4: A register is released only in the cycle its count goes from nonzero to zero. A deallocation that leaves the count above zero releases nothing.
- R5: Deallocate inputs sampled on clock edge T update the counters at edge T, and the resulting release shows on the outputs after edge T+1.
- R6: Allocate and deallocate ports that name register 0 have no effect, and register 0 never appears on a release port.
- R7: Several ports that name the same register in one cycle are summed, and the net change is applied in one update.
- R8: An allocate and a deallocate of the same register in the same cycle leave its count unchanged and produce no release.
- R9: When several deallocate ports release the same register in one cycle, only the lowest-numbered of those ports reports it, on releaseValid[p] and releaseIdx[p]. The other release ports stay low for that register.
- R10: Counters hold values from 0 up to NUM_PORTS*MAX_SHARERS without wrapping. An update that would go below zero or above that limit is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | NUM_PORTS | Allocate request per port |
| allocIdx | input | NUM_PORTS x IDX_W | Physical register named by each allocate port |
| deallocValid | input | NUM_PORTS | Deallocate request per port |
| deallocIdx | input | NUM_PORTS x IDX_W | Physical register named by each deallocate port |
| releaseValid | output | NUM_PORTS | Register freed, per port |
| releaseIdx | output | NUM_PORTS x IDX_W | Index of the freed register |

## Verification
The bench builds the block with its default values: 64 physical registers, 32 architectural registers, two ports each way and eight sharers per port, which gives a count ceiling of 16. The random traffic draws from a small pool of registers. That pool mixes register 0, registers that start at one and registers that start at zero, so same-register collisions across ports and within one cycle happen often. Directed steps drive one register up to the ceiling of 16 and back down, so the widest counter value is reached.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;
  // Number of allocate ports, which is also the number of deallocate and release ports
  localparam int RC_PORTS = 2;

  // Qualified strobes that the control sends to the datapath
  typedef struct packed {
    logic [RC_PORTS-1:0] allocUse;     // allocate is valid and names a nonzero register
    logic [RC_PORTS-1:0] deallocUse;   // deallocate is valid and names a nonzero register
    logic [RC_PORTS-1:0] deallocFirst; // lowest-numbered deallocate port naming that register
  } rcStrobes_t;
endpackage

// File: rtl/refcnt_ctrl.sv
module refcnt_ctrl
  import refcnt_pkg::*;
#(
  parameter int NUM_PORTS = RC_PORTS,
  parameter int IDX_W     = 6
) (
  input  logic [NUM_PORTS-1:0]            allocValid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] allocIdx,
  input  logic [NUM_PORTS-1:0]            deallocValid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] deallocIdx,
  output rcStrobes_t                      strobes
);
  always_comb begin
    strobes = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      // Register 0 is pinned: any port that names it is dropped here
      strobes.allocUse[p]   = allocValid[p]   && (allocIdx[p]   != '0);
      strobes.deallocUse[p] = deallocValid[p] && (deallocIdx[p] != '0);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobes.deallocFirst[p] = strobes.deallocUse[p];
      for (int q = 0; q < p; q++) begin
        if (strobes.deallocUse[q] && (deallocIdx[q] == deallocIdx[p]))
          strobes.deallocFirst[p] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/refcnt_dp.sv
module refcnt_dp
  import refcnt_pkg::*;
#(
  parameter int NUM_PORTS = RC_PORTS,
  parameter int NUM_PREGS = 64,
  parameter int NUM_ARCH  = 32,
  parameter int IDX_W     = 6,
  parameter int CNT_W     = 5,
  parameter int MAX_CNT   = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  rcStrobes_t                      strobes,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] allocIdx,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] deallocIdx,
  output logic [NUM_PORTS-1:0]            releaseValid,
  output logic [NUM_PORTS-1:0][IDX_W-1:0] releaseIdx
);
  localparam int WIDE_W = CNT_W + 2;

  logic        [CNT_W-1:0]  cnt      [NUM_PREGS];
  logic signed [WIDE_W-1:0] nextWide [NUM_PREGS];

  logic [NUM_PORTS-1:0]            relCand;
  logic [NUM_PORTS-1:0]            stgValid;
  logic [NUM_PORTS-1:0][IDX_W-1:0] stgIdx;

  for (genvar r = 0; r < NUM_PREGS; r++) begin : gCnt
    localparam logic [CNT_W-1:0] RST_VAL =
      ((r >= 1) && (r < NUM_ARCH)) ? CNT_W'(1) : '0;

    always_comb begin
      int sum;
      sum = int'(cnt[r]);
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobes.allocUse[p]   && (int'(allocIdx[p])   == r)) sum = sum + 1;
        if (strobes.deallocUse[p] && (int'(deallocIdx[p]) == r)) sum = sum - 1;
      end
      nextWide[r] = WIDE_W'(sum);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt[r] <= RST_VAL;
      else       cnt[r] <= nextWide[r][CNT_W-1:0];
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      (nextWide[r] >= 0) && (nextWide[r] <= WIDE_W'(MAX_CNT))); // R10
  end

  // A register is freed only when its count goes from nonzero to zero
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      relCand[p] = strobes.deallocFirst[p]
                && (cnt[deallocIdx[p]] != '0)
                && (nextWide[deallocIdx[p]] == '0);
    end
  end

  // Stage 1 is captured together with the counter update; the output stage follows one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid     <= '0;
      stgIdx       <= '0;
      releaseValid <= '0;
      releaseIdx   <= '0;
    end else begin
      stgValid     <= relCand;
      stgIdx       <= deallocIdx;
      releaseValid <= stgValid;
      releaseIdx   <= stgIdx;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gChk
    AST_STAGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      stgValid[p] |-> (cnt[stgIdx[p]] == '0)); // R4
    AST_NOT_REG0: assert property (@(posedge clk) disable iff (!rstN)
      releaseValid[p] |-> (releaseIdx[p] != '0)); // R6
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : gPair
      AST_RELEASE_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
        (releaseValid[p] && releaseValid[q]) |-> (releaseIdx[p] != releaseIdx[q])); // R9
    end
  end
endmodule

// File: rtl/preg_refcount.sv
module preg_refcount
  import refcnt_pkg::*;
#(
  parameter int NUM_PORTS   = RC_PORTS,
  parameter int NUM_PREGS   = 64,
  parameter int NUM_ARCH    = 32,
  parameter int MAX_SHARERS = 8,
  parameter int IDX_W       = $clog2(NUM_PREGS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS-1:0]            allocValid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] allocIdx,
  input  logic [NUM_PORTS-1:0]            deallocValid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] deallocIdx,
  output logic [NUM_PORTS-1:0]            releaseValid,
  output logic [NUM_PORTS-1:0][IDX_W-1:0] releaseIdx
);
  localparam int MAX_CNT = NUM_PORTS * MAX_SHARERS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  rcStrobes_t strobes;

  refcnt_ctrl #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_ctrl (
    .allocValid  (allocValid),
    .allocIdx    (allocIdx),
    .deallocValid(deallocValid),
    .deallocIdx  (deallocIdx),
    .strobes     (strobes)
  );

  refcnt_dp #(
    .NUM_PORTS(NUM_PORTS), .NUM_PREGS(NUM_PREGS), .NUM_ARCH(NUM_ARCH),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_CNT(MAX_CNT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .allocIdx    (allocIdx),
    .deallocIdx  (deallocIdx),
    .releaseValid(releaseValid),
    .releaseIdx  (releaseIdx)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gTop
    AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (!rstN)
      releaseValid[p] |-> ($past(deallocValid[p], 2) && ($past(deallocIdx[p], 2) == releaseIdx[p]))); // R5
  end
endmodule

// File: tb/preg_refcount_tb.sv
module preg_refcount_tb;
  localparam int NP    = 2;
  localparam int NPREG = 64;
  localparam int NARCH = 32;
  localparam int MAXC  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]      allocValid = '0;
  logic [NP-1:0][5:0] allocIdx = '0;
  logic [NP-1:0]      deallocValid = '0;
  logic [NP-1:0][5:0] deallocIdx = '0;
  logic [NP-1:0]      releaseValid;
  logic [NP-1:0][5:0] releaseIdx;

  always #4 clk = ~clk;

  preg_refcount u_dut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIdx(allocIdx),
    .deallocValid(deallocValid), .deallocIdx(deallocIdx),
    .releaseValid(releaseValid), .releaseIdx(releaseIdx)
  );

  int checks = 0;
  int errors = 0;
  int mcnt [NPREG];
  bit [NP-1:0] pipeV [2];
  int          pipeI [2][NP];
  string       pipeT [2];
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Compare the outputs with the entry that has aged two cycles, then drive a new cycle
  task automatic step(input bit av0, input int a0, input bit av1, input int a1,
                      input bit dv0, input int d0, input bit dv1, input int d1,
                      input string tag);
    int old [NPREG];
    bit [NP-1:0] ev;
    int ei [NP];
    int di [NP];
    bit dvv [NP];
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (releaseValid[p] !== pipeV[1][p] ||
          (pipeV[1][p] && (int'(releaseIdx[p]) != pipeI[1][p]))) begin
        errors++;
        $display("FAIL %s port %0d: actual v=%0b idx=%0d expected v=%0b idx=%0d",
                 pipeT[1], p, releaseValid[p], releaseIdx[p], pipeV[1][p], pipeI[1][p]);
      end
    end
    pipeV[1] = pipeV[0]; pipeI[1] = pipeI[0]; pipeT[1] = pipeT[0];
    old = mcnt;
    if (av0 && a0 != 0) mcnt[a0]++;
    if (av1 && a1 != 0) mcnt[a1]++;
    if (dv0 && d0 != 0) mcnt[d0]--;
    if (dv1 && d1 != 0) mcnt[d1]--;
    di[0] = d0; di[1] = d1; dvv[0] = dv0; dvv[1] = dv1;
    ev = '0;
    for (int p = 0; p < NP; p++) begin
      bit first;
      first = 1'b1;
      for (int q = 0; q < p; q++) if (dvv[q] && di[q] == di[p]) first = 1'b0;
      ei[p] = di[p];
      if (dvv[p] && di[p] != 0 && first && old[di[p]] > 0 && mcnt[di[p]] == 0) ev[p] = 1'b1;
    end
    pipeV[0] = ev; pipeI[0] = ei; pipeT[0] = tag;
    allocValid = {av1, av0};  allocIdx = {6'(a1), 6'(a0)};
    deallocValid = {dv1, dv0}; deallocIdx = {6'(d1), 6'(d0)};
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int r = 0; r < NPREG; r++) mcnt[r] = (r >= 1 && r < NARCH) ? 1 : 0;
    pipeV[0] = '0; pipeV[1] = '0;
    pipeT[0] = "R1"; pipeT[1] = "R1";
    for (int p = 0; p < NP; p++) begin pipeI[0][p] = 0; pipeI[1][p] = 0; end

    // R1: nothing released while reset is held
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (releaseValid !== '0) begin
        errors++;
        $display("FAIL R1 reset: actual %b expected 00", releaseValid);
      end
    end
    rstN = 1'b1;
    idle(2, "R1");

    // R2: architectural register 5 starts at one
    step(0, 0, 0, 0, 1, 5, 0, 0, "R2");
    idle(2, "R2");
    // R2, R3: register 40 starts at zero; allocate then deallocate
    step(1, 40, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 40, 0, 0, "R2");
    idle(2, "R5");
    // R7: two allocates of 41 in one cycle; R4: first deallocate leaves a sharer
    step(1, 41, 1, 41, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 41, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 41, "R4");
    idle(2, "R4");
    // R8: allocate and deallocate 7 together, then a lone deallocate
    step(1, 7, 0, 0, 0, 0, 1, 7, "R8");
    idle(2, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 7, "R8");
    idle(2, "R8");
    // R9: both deallocate ports free 42 together; only port 0 reports
    step(1, 42, 1, 42, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 42, 1, 42, "R9");
    idle(2, "R9");
    // R9: port 1 alone releases 8
    step(0, 0, 0, 0, 0, 0, 1, 8, "R9");
    idle(2, "R9");
    // R6: register 0 on every port has no effect
    step(1, 0, 1, 0, 1, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R6");
    idle(2, "R6");
    // R10: drive 50 to the ceiling and back down
    for (int i = 0; i < MAXC / 2; i++) step(1, 50, 1, 50, 0, 0, 0, 0, "R10");
    for (int i = 0; i < MAXC / 2; i++) step(0, 0, 0, 0, 1, 50, 1, 50, "R10");
    idle(2, "R10");

    // R3: random traffic on a narrow pool of registers
    for (int c = 0; c < 4000; c++) begin
      int t [NPREG];
      bit av [NP]; int a [NP]; bit dv [NP]; int d [NP];
      t = mcnt;
      for (int p = 0; p < NP; p++) begin
        int r;
        r = $urandom_range(0, 19);
        a[p] = (r < 12) ? r : 28 + r;
        av[p] = ($urandom_range(0, 1) == 1) && (t[a[p]] < MAXC);
        if (av[p] && a[p] != 0) t[a[p]]++;
      end
      for (int p = 0; p < NP; p++) begin
        int r;
        r = $urandom_range(0, 19);
        d[p] = (r < 12) ? r : 28 + r;
        dv[p] = ($urandom_range(0, 2) != 0) && (d[p] == 0 || t[d[p]] > 0);
        if (dv[p] && d[p] != 0) t[d[p]]--;
      end
      step(av[0], a[0], av[1], a[1], dv[0], d[0], dv[1], d[1], "R3");
    end
    idle(3, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule